// File: doc/BRIEF.md
# Delay-Locked Loop Code Controller

This block is the digital half of a delay-locked loop that tunes the delay chains on data-strobe inputs. A phase comparator outside the block reports once per reference clock cycle whether the delay line is early or late. The block keeps a binary delay code in a saturating up/down counter and moves it one step toward balance. The loop keeps running after lock, so the code follows slow drift in process, voltage and temperature.

Two setting outputs drive the delay chains. Each one adds its own signed phase offset to the shared code, clamps the sum, and sends it out Gray-coded. One loop therefore serves two phase shifts, and each normal update changes only a single wire. A lock-valid flag tells consumers when the settings may be trusted. It rises only after a settling window whose length depends on the mode. In low-jitter mode the window is 1280 cycles and the counter steps at most once per eight-cycle majority vote. In normal mode the window is 256 cycles and the counter steps every cycle.

Top module: `dll_ctrl`

## Requirements
- R1: While reset is asserted, lock_valid is 0, both settings are 0 and the internal code is set to 64. The mode history is taken as normal mode.
- R2: In normal mode, lock_valid is 0 for the first 255 rising edges that see enable high with an unchanged mode. It is 1 after the 256th such edge.
- R3: In low-jitter mode, the same rule as R2 applies with a window of 1280 edges.
- R4: An edge with enable low restarts the lock window and clears lock_valid on that edge. So does an edge where low_jitter differs from its value at the previous edge.
- R5: In normal mode, each non-restart edge raises the code by 1 when early is 1 and lowers it by 1 when early is 0. In a closed loop the code settles within one step of the target.
- R6: In low-jitter mode, the early bits of eight consecutive non-restart edges are counted, and the decision is applied on the eighth edge. More than 4 raises the code by 1, fewer than 4 lowers it by 1, and exactly 4 leaves it unchanged. A restart empties the count.
- R7: The code saturates at 0 and 127 and never wraps.
- R8: After each edge, each setting equals the Gray code (b xor b>>1) of clamp(code + offset, 0, 127). Here code is the value held before that edge, and offset is a 7-bit two's complement value.
- R9: If a setting's offset has been unchanged for the last two edges, consecutive values of that setting differ in at most one bit.
- R10: On a restart edge the code holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Loop enable; low restarts the lock window |
| low_jitter | input | 1 | 1 selects low-jitter mode (1280-cycle window, voted updates) |
| early | input | 1 | Comparator result: 1 = early (raise code), 0 = late (lower code) |
| offset_a | input | 7 | Signed phase offset for setting A |
| offset_b | input | 7 | Signed phase offset for setting B |
| setting_a | output | 7 | Gray-coded delay setting A |
| setting_b | output | 7 | Gray-coded delay setting B |
| lock_valid | output | 1 | Settings are settled and may be used |

## Verification
In low-jitter mode the lock window is a multiple of the vote length. The edge that raises lock_valid is therefore also the edge that applies a vote decision, so the flag and a code step land together. The bench opens the window at vote phase zero with a pattern whose early count differs from window to window. It then compares the flag edge and the stepped setting against its own arithmetic model on that same cycle. A mode flip issued while locked makes a restart coincide with a pending vote, and the bench checks that the count is discarded and the code holds.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOWJIT = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/dll_lock_timer.sv
module dll_lock_timer
    import dll_ctrl_pkg::*;
#(
    parameter int LOCK_LONG  = 1280,
    parameter int LOCK_SHORT = 256
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  mode_e mode,
    output logic  restart_o,
    output logic  lock_o
);
    localparam int CNT_W = $clog2(LOCK_LONG + 1);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LOCK_LONG);
    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(LOCK_SHORT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        mode_e            mode;
        logic             lock;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] target;
    logic             restart;

    always_comb begin
        target  = (mode == MODE_LOWJIT) ? LONG_C : SHORT_C;
        restart = !enable || (mode != tmr_q.mode);
        tmr_d      = tmr_q;
        tmr_d.mode = mode;
        if (restart) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt < target) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        tmr_d.lock = !restart && (tmr_d.cnt == target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{cnt: '0, mode: MODE_NORMAL, lock: 1'b0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign restart_o = restart;
    assign lock_o    = tmr_q.lock;

    // R4: a restart edge always leaves the flag low
    a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tmr_q.lock);
    // R2 / R3: the flag rises only when the previous count was one short of the window
    a_r2_r3_rise_at_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.lock) |-> ($past(tmr_q.cnt) ==
            ((tmr_q.mode == MODE_LOWJIT) ? LONG_C - 1'b1 : SHORT_C - 1'b1)));
endmodule

// File: rtl/dll_code_track.sv
module dll_code_track
    import dll_ctrl_pkg::*;
#(
    parameter int CODE_W   = 7,
    parameter int VOTE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  mode_e             mode,
    input  logic              early,
    output logic [CODE_W-1:0] code_o
);
    localparam int PH_W = $clog2(VOTE_LEN);
    localparam int VT_W = $clog2(VOTE_LEN + 1);
    localparam logic [CODE_W-1:0] MAX_C  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MID_C  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [PH_W-1:0]   LAST_P = PH_W'(VOTE_LEN - 1);
    localparam logic [VT_W-1:0]   HALF_V = VT_W'(VOTE_LEN / 2);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PH_W-1:0]   phase;
        logic [VT_W-1:0]   votes;
    } trk_t;

    trk_t trk_d, trk_q;
    step_e step;
    logic [VT_W-1:0] total;

    always_comb begin
        trk_d = trk_q;
        step  = STEP_HOLD;
        total = trk_q.votes + VT_W'(early);
        if (restart) begin
            trk_d.phase = '0;
            trk_d.votes = '0;
        end else if (mode == MODE_NORMAL) begin
            step = early ? STEP_UP : STEP_DOWN;
        end else if (trk_q.phase == LAST_P) begin
            if (total > HALF_V)      step = STEP_UP;
            else if (total < HALF_V) step = STEP_DOWN;
            trk_d.phase = '0;
            trk_d.votes = '0;
        end else begin
            trk_d.phase = trk_q.phase + 1'b1;
            trk_d.votes = total;
        end
        if (step == STEP_UP && trk_q.code != MAX_C) begin
            trk_d.code = trk_q.code + 1'b1;
        end else if (step == STEP_DOWN && trk_q.code != '0) begin
            trk_d.code = trk_q.code - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{code: MID_C, phase: '0, votes: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign code_o = trk_q.code;

    // R10: code frozen across a restart edge
    a_r10_hold_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> $stable(trk_q.code));
    // R6: in low-jitter mode the code moves only at the end of a vote window
    a_r6_step_on_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOWJIT && !restart && trk_q.phase != LAST_P) |=> $stable(trk_q.code));
    // R7: no wrap at either end
    a_r7_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.code == MAX_C) |=> (trk_q.code >= MAX_C - 1'b1));
    a_r7_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.code == '0) |=> (trk_q.code <= CODE_W'(1)));
endmodule

// File: rtl/dll_phase_out.sv
module dll_phase_out #(
    parameter int CODE_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CODE_W-1:0]        code,
    input  logic signed [CODE_W-1:0] offset_i,
    output logic [CODE_W-1:0]        setting_o
);
    localparam int SUM_W = CODE_W + 2;
    localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << CODE_W) - 1);

    typedef struct packed {
        logic [CODE_W-1:0] set;
        logic [1:0]        primed;
    } out_t;

    out_t out_d, out_q;
    logic signed [SUM_W-1:0] sum;
    logic [CODE_W-1:0]       clamped;

    always_comb begin
        sum = $signed({2'b00, code}) + SUM_W'(offset_i);
        if (sum < 0)          clamped = '0;
        else if (sum > MAX_S) clamped = MAX_S[CODE_W-1:0];
        else                  clamped = sum[CODE_W-1:0];
        out_d.set    = clamped ^ (clamped >> 1);
        out_d.primed = (out_q.primed == 2'd3) ? 2'd3 : out_q.primed + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign setting_o = out_q.set;

    // R9: with a held offset, each update flips at most one wire
    a_r9_single_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.primed == 2'd3 && $past(offset_i) == $past(offset_i, 2))
            |-> ($countones(out_q.set ^ $past(out_q.set)) <= 1));
endmodule

// File: rtl/dll_ctrl.sv
module dll_ctrl
    import dll_ctrl_pkg::*;
#(
    parameter int CODE_W     = 7,
    parameter int VOTE_LEN   = 8,
    parameter int LOCK_LONG  = 1280,
    parameter int LOCK_SHORT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              low_jitter,
    input  logic              early,
    input  logic [CODE_W-1:0] offset_a,
    input  logic [CODE_W-1:0] offset_b,
    output logic [CODE_W-1:0] setting_a,
    output logic [CODE_W-1:0] setting_b,
    output logic              lock_valid
);
    localparam int N_OUT = 2;

    mode_e             mode;
    logic              restart;
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] offs [N_OUT];
    logic [CODE_W-1:0] sets [N_OUT];

    assign mode    = mode_e'(low_jitter);
    assign offs[0] = offset_a;
    assign offs[1] = offset_b;

    dll_lock_timer #(.LOCK_LONG(LOCK_LONG), .LOCK_SHORT(LOCK_SHORT)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .restart_o(restart), .lock_o(lock_valid)
    );

    dll_code_track #(.CODE_W(CODE_W), .VOTE_LEN(VOTE_LEN)) u_track (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mode(mode),
        .early(early), .code_o(code)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        dll_phase_out #(.CODE_W(CODE_W)) u_out (
            .clk(clk), .rst_n(rst_n), .code(code),
            .offset_i($signed(offs[i])), .setting_o(sets[i])
        );
    end

    assign setting_a = sets[0];
    assign setting_b = sets[1];
endmodule

// File: tb/dll_ctrl_tb.sv
module dll_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 256;
    localparam int NL = 1280;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, low_jitter = 1'b0, early = 1'b0;
    logic signed [6:0] offset_a = '0, offset_b = '0;
    logic [6:0] setting_a, setting_b;
    logic lock_valid;

    dll_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .low_jitter(low_jitter),
        .early(early), .offset_a(offset_a), .offset_b(offset_b),
        .setting_a(setting_a), .setting_b(setting_b), .lock_valid(lock_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_vec = 0, n_bad = 0;
    int m_code = 64, m_cnt = 0, m_phase = 0, m_votes = 0;
    bit m_modeq = 1'b0;
    int prev_a = 0, prev_b = 0, st_a = 0, st_b = 0;
    logic signed [6:0] last_a = '0, last_b = '0;
    bit done = 1'b0;

    function automatic int clampc(int v);
        return (v < 0) ? 0 : ((v > 127) ? 127 : v);
    endfunction
    function automatic int gray(int b);
        return b ^ (b >> 1);
    endfunction
    function automatic int ungray(int g);
        int b = g;
        for (int s = g >> 1; s != 0; s = s >> 1) b = b ^ s;
        return b;
    endfunction

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one reference cycle: drive at negedge, model, observe at next negedge
    task automatic cyc(bit e, string tag);
        int old;
        bit rs;
        int v;
        bit exp_lock;
        early = e;
        if (offset_a != last_a) st_a = 0;
        if (offset_b != last_b) st_b = 0;
        last_a = offset_a;
        last_b = offset_b;
        old = m_code;
        rs = !enable || (low_jitter != m_modeq);
        m_modeq = low_jitter;
        if (rs) begin
            m_cnt = 0; m_phase = 0; m_votes = 0;
        end else begin
            if (m_cnt < (low_jitter ? NL : NS)) m_cnt++;
            if (!low_jitter) begin
                m_code = clampc(m_code + (e ? 1 : -1));
            end else if (m_phase == 7) begin
                v = m_votes + int'(e);
                if (v > 4) m_code = clampc(m_code + 1);
                else if (v < 4) m_code = clampc(m_code - 1);
                m_phase = 0; m_votes = 0;
            end else begin
                m_phase++; m_votes += int'(e);
            end
        end
        exp_lock = !rs && (m_cnt == (low_jitter ? NL : NS));
        @(posedge clk);
        @(negedge clk);
        check(rs ? "R4 lock" : (low_jitter ? "R3 lock" : "R2 lock"), int'(lock_valid), int'(exp_lock));
        check({tag, "/R8 setting_a"}, int'(setting_a), gray(clampc(old + int'(offset_a))));
        check({tag, "/R8 setting_b"}, int'(setting_b), gray(clampc(old + int'(offset_b))));
        if (st_a >= 1) check("R9 one-bit a", int'($countones(setting_a ^ 7'(prev_a)) <= 1), 1);
        if (st_b >= 1) check("R9 one-bit b", int'($countones(setting_b ^ 7'(prev_b)) <= 1), 1);
        st_a++; st_b++;
        prev_a = int'(setting_a);
        prev_b = int'(setting_b);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        check("R1 lock in reset", int'(lock_valid), 0);
        check("R1 setting_a in reset", int'(setting_a), 0);
        check("R1 setting_b in reset", int'(setting_b), 0);
        rst_n = 1'b1;
        // enable low: code held at 64 (R1, R10)
        for (int i = 0; i < 3; i++) cyc(i[0], "R10");
        check("R1 code 64", ungray(int'(setting_a)), 64);

        // normal mode closed loop toward 20, lock at 256 (R2, R5)
        offset_b = 7'sd5;
        enable = 1'b1;
        for (int i = 0; i < 300; i++) cyc(m_code < 20, "R5");
        d = ungray(int'(setting_a)) - 20;
        check("R5 converged", int'(d >= -1 && d <= 1), 1);

        // saturation at both ends (R7)
        offset_b = 7'sd10;
        for (int i = 0; i < 140; i++) cyc(1'b1, "R7");
        check("R7 top", ungray(int'(setting_a)), 127);
        check("R7 top b", ungray(int'(setting_b)), 127);
        offset_b = -7'sd10;
        for (int i = 0; i < 140; i++) cyc(1'b0, "R7");
        check("R7 bottom", ungray(int'(setting_a)), 0);
        check("R7 bottom b", ungray(int'(setting_b)), 0);

        // enable low while locked: flag drops, code holds (R4, R10)
        enable = 1'b0;
        for (int i = 0; i < 5; i++) cyc(1'b1, "R10");
        check("R10 held", ungray(int'(setting_a)), 0);
        enable = 1'b1;
        for (int i = 0; i < 40; i++) cyc(1'b1, "R5");

        // low-jitter: mode change restarts; vote counts 0..8 per window (R3, R6)
        low_jitter = 1'b1;
        for (int w = 0; w < 170; w++)
            for (int p = 0; p < 8; p++) cyc(p < (w % 9), "R6");
        // closed loop in low-jitter mode toward 90
        for (int i = 0; i < 600; i++) cyc(m_code < 90, "R6");
        d = ungray(int'(setting_a)) - 90;
        check("R6 converged", int'(d >= -1 && d <= 1), 1);

        // mode flip mid-window while locked (R4)
        for (int i = 0; i < 3; i++) cyc(1'b1, "R6");
        low_jitter = 1'b0;
        for (int i = 0; i < 4; i++) cyc(1'b0, "R4");

        // offset sweep over the full signed range (R8)
        for (int o = -64; o < 64; o++) begin
            offset_a = 7'(o);
            offset_b = 7'(-o - 1);
            cyc(o[0], "R8");
        end
        offset_a = '0;
        for (int i = 0; i < 4; i++) cyc(1'b1, "R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule